// File: doc/BRIEF.md
# Saturating Age-Counter Replacement State

This block holds the replacement state of an N-way set-associative cache. Each way of each set has a small age counter that counts downward and stops at zero. A high age marks a recently used way. A low age marks a candidate for eviction. The cache controller drives one request per cycle. The request carries a set index, a way number and an operation code. The operation is a hit update, a fill update, an invalidate or a plain victim query.

The victim way for the addressed set is a combinational output. A miss handler reads the victim, fetches the line, and then issues a fill to that way. The number of age states can be set from 2 to 4 at elaboration. Every update is a read-modify-write of one set's counters, and the new values are written at the next rising clock edge. Tag comparison and line data are handled elsewhere.

Top module: `age_lru_repl`

## Requirements
- R1: After reset every age counter of every set is 0, so the victim output of every set is way 0.
- R2: A valid request with operation code 2'b01 (hit) decrements by one each other way of the addressed set whose age is strictly greater than the hit way's age before the update. It then sets the hit way to the maximum age, which is the number of age states minus 1. Other ways keep their ages.
- R3: A valid request with operation code 2'b10 (fill) decrements by one every other way of the addressed set whose age is nonzero. It then sets the filled way to the maximum age.
- R4: A valid request with operation code 2'b11 (invalidate) sets the addressed way's age to 0 and leaves the other ways of that set unchanged.
- R5: The victim output is the lowest-indexed way holding the smallest age among the ways whose age is below the maximum. If every way is at the maximum, the victim is way 0. It is derived combinationally from the set index in the same cycle.
- R6: Operation code 2'b00 (victim query), and any cycle with the request valid input low, leave all ages unchanged.
- R7: A request changes only the set it addresses. The ages of all other sets are unaffected.
- R8: An update becomes visible on the victim output only after the next rising clock edge. During the request cycle the output still reflects the ages from before the update.
- R9: With two age states the ages are 0 or 1, and the same hit, fill, invalidate and victim rules apply with a maximum age of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | 00 query, 01 hit, 10 fill, 11 invalidate |
| reqSet | input | $clog2(NUM_SETS) | Set index for both the update and the victim output |
| reqWay | input | $clog2(NUM_WAYS) | Way addressed by hit, fill or invalidate |
| victimWay | output | $clog2(NUM_WAYS) | Replacement candidate for reqSet |

## Verification
The assertions assume that the set index is held for at least two consecutive cycles whenever they relate the victim output to a preceding request. When the set changes from one cycle to the next, each property becomes vacuous. The assertions also assume that reset is asserted at time zero, so that the first rise of rstN follows a full clear. The stimulus starts in reset, applies the directed sequences on a single set, and then draws random operations that often repeat a set from a small pool. This keeps the set stable often enough that the checked consequents are actually reached. Full sweeps of all sets, with the request valid input low, expose state through the victim output without disturbing it.

// File: rtl/agelru_pkg.sv
package agelru_pkg;

  typedef enum logic [1:0] {
    OP_QUERY = 2'b00,
    OP_HIT   = 2'b01,
    OP_FILL  = 2'b10,
    OP_INV   = 2'b11
  } ageOp_e;

  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic hitStb;
    logic fillStb;
    logic invStb;
  } ageStrobe_t;

  localparam int AGE_W = 2;

endpackage

// File: rtl/agelru_ctrl.sv
module agelru_ctrl
  import agelru_pkg::*;
(
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  output ageStrobe_t strobe
);

  ageOp_e opCode;

  always_comb begin
    opCode = ageOp_e'(reqOp);
    strobe = '0;
    if (reqValid) begin
      unique case (opCode)
        OP_HIT:   strobe.hitStb  = 1'b1;
        OP_FILL:  strobe.fillStb = 1'b1;
        OP_INV:   strobe.invStb  = 1'b1;
        default:  strobe         = '0;
      endcase
    end
  end

endmodule

// File: rtl/agelru_victim.sv
module agelru_victim
  import agelru_pkg::*;
#(
  parameter int NUM_WAYS   = 4,
  parameter int AGE_STATES = 4,
  localparam int WAY_W     = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0][AGE_W-1:0] rowAges,
  output logic [WAY_W-1:0]               victimWay
);

  localparam logic [AGE_W-1:0] MAX_AGE = AGE_W'(AGE_STATES - 1);

  logic [AGE_W-1:0] bestAge;

  // Strict less-than scan: the first way holding the lowest sub-maximum age wins.
  always_comb begin
    bestAge   = MAX_AGE;
    victimWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (rowAges[w] < bestAge) begin
        bestAge   = rowAges[w];
        victimWay = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/agelru_datapath.sv
module agelru_datapath
  import agelru_pkg::*;
#(
  parameter int NUM_SETS   = 16,
  parameter int NUM_WAYS   = 4,
  parameter int AGE_STATES = 4,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int WAY_W     = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ageStrobe_t       strobe,
  input  logic [SET_W-1:0] reqSet,
  input  logic [WAY_W-1:0] reqWay,
  output logic [WAY_W-1:0] victimWay
);

  localparam logic [AGE_W-1:0] MAX_AGE = AGE_W'(AGE_STATES - 1);

  logic [NUM_SETS-1:0][NUM_WAYS-1:0][AGE_W-1:0] ageMem;
  logic [NUM_WAYS-1:0][AGE_W-1:0]               rowCur;
  logic [NUM_WAYS-1:0][AGE_W-1:0]               rowNext;
  logic [AGE_W-1:0]                             refAge;
  logic                                         anyWrite;

  assign rowCur   = ageMem[reqSet];
  assign refAge   = rowCur[reqWay];
  assign anyWrite = strobe.hitStb | strobe.fillStb | strobe.invStb;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic isTarget;
    assign isTarget = (reqWay == WAY_W'(w));

    always_comb begin
      rowNext[w] = rowCur[w];
      if (isTarget) begin
        if (strobe.invStb)
          rowNext[w] = '0;
        else if (strobe.hitStb || strobe.fillStb)
          rowNext[w] = MAX_AGE;
      end else if (strobe.hitStb) begin
        if (rowCur[w] > refAge)
          rowNext[w] = rowCur[w] - 1'b1;
      end else if (strobe.fillStb) begin
        if (rowCur[w] != '0)
          rowNext[w] = rowCur[w] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ageMem <= '0;
    else if (anyWrite)
      ageMem[reqSet] <= rowNext;
  end

  agelru_victim #(
    .NUM_WAYS  (NUM_WAYS),
    .AGE_STATES(AGE_STATES)
  ) u_victim (
    .rowAges  (rowCur),
    .victimWay(victimWay)
  );

endmodule

// File: rtl/age_lru_repl.sv
module age_lru_repl
  import agelru_pkg::*;
#(
  parameter int NUM_SETS   = 16,
  parameter int NUM_WAYS   = 4,
  parameter int AGE_STATES = 4,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int WAY_W     = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [SET_W-1:0] reqSet,
  input  logic [WAY_W-1:0] reqWay,
  output logic [WAY_W-1:0] victimWay
);

  if (AGE_STATES < 2 || AGE_STATES > 4) begin : g_badStates
    $error("AGE_STATES must lie between 2 and 4");
  end
  if ((NUM_WAYS < 2) || ((NUM_WAYS & (NUM_WAYS - 1)) != 0)) begin : g_badWays
    $error("NUM_WAYS must be a power of two of at least 2");
  end

  ageStrobe_t strobe;

  agelru_ctrl u_ctrl (
    .reqValid(reqValid),
    .reqOp   (reqOp),
    .strobe  (strobe)
  );

  agelru_datapath #(
    .NUM_SETS  (NUM_SETS),
    .NUM_WAYS  (NUM_WAYS),
    .AGE_STATES(AGE_STATES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqSet   (reqSet),
    .reqWay   (reqWay),
    .victimWay(victimWay)
  );

endmodule

// File: rtl/agelru_checker.sv
module agelru_checker #(
  parameter int SET_W = 4,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       reqOp,
  input logic [SET_W-1:0] reqSet,
  input logic [WAY_W-1:0] reqWay,
  input logic [WAY_W-1:0] victimWay
);

  // R1: the first cycle out of reset sees cleared ages, so the victim is way 0
  a_r1_reset_victim_zero: assert property (@(posedge clk)
    $rose(rstN) |-> victimWay == '0);

  // R2: a way just hit holds the maximum age and cannot be chosen unless it is way 0
  a_r2_hit_not_victim: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b01 && reqWay != '0)
    |=> (reqSet != $past(reqSet)) || (victimWay != $past(reqWay)));

  // R3: a way just filled holds the maximum age and cannot be chosen unless it is way 0
  a_r3_fill_not_victim: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b10 && reqWay != '0)
    |=> (reqSet != $past(reqSet)) || (victimWay != $past(reqWay)));

  // R4: an invalidated way has age 0, so the victim lies at or below its index
  a_r4_inv_bounds_victim: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b11)
    |=> (reqSet != $past(reqSet)) || (victimWay <= $past(reqWay)));

  // R6: queries and idle cycles leave the addressed set's victim unchanged
  a_r6_query_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqOp == 2'b00)
    |=> (reqSet != $past(reqSet)) || $stable(victimWay));

endmodule

bind age_lru_repl agelru_checker #(
  .SET_W(SET_W),
  .WAY_W(WAY_W)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqOp    (reqOp),
  .reqSet   (reqSet),
  .reqWay   (reqWay),
  .victimWay(victimWay)
);

// File: tb/age_lru_repl_tb.sv
`timescale 1ns/1ps
module age_lru_repl_tb;

  localparam int SETS = 16;
  localparam int WAYS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqOp = 2'b00;
  logic [3:0] reqSet = '0;
  logic [1:0] reqWay = '0;
  logic [1:0] victimWay;
  logic [1:0] victimWayTwo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mAge [2][SETS][WAYS];
  int maxA [2] = '{3, 1};

  always #4 clk = ~clk;

  age_lru_repl #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .AGE_STATES(4)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqSet(reqSet), .reqWay(reqWay), .victimWay(victimWay));

  // R9: second instance with two age states, same stimulus
  age_lru_repl #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .AGE_STATES(2)) u_dutTwo (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqSet(reqSet), .reqWay(reqWay), .victimWay(victimWayTwo));

  function automatic int modelVictim(int k, int s);
    int best = maxA[k];
    int vw = 0;
    for (int i = 0; i < WAYS; i++)
      if (mAge[k][s][i] < best) begin
        best = mAge[k][s][i];
        vw = i;
      end
    return vw;
  endfunction

  task automatic modelApply(int op, int s, int w);
    for (int k = 0; k < 2; k++) begin
      int ref0 = mAge[k][s][w];
      if (op == 1) begin
        for (int i = 0; i < WAYS; i++)
          if (i != w && mAge[k][s][i] > ref0) mAge[k][s][i]--;
        mAge[k][s][w] = maxA[k];
      end else if (op == 2) begin
        for (int i = 0; i < WAYS; i++)
          if (i != w && mAge[k][s][i] != 0) mAge[k][s][i]--;
        mAge[k][s][w] = maxA[k];
      end else if (op == 3) begin
        mAge[k][s][w] = 0;
      end
    end
  endtask

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic checkBoth(string tag, int s);
    check({tag, " states=4"}, int'(victimWay), modelVictim(0, s));
    check({tag, " R9 states=2"}, int'(victimWayTwo), modelVictim(1, s));
  endtask

  // Drive one request; the victim is sampled before the edge (R8), model updated after.
  task automatic doOp(int op, int s, int w);
    @(negedge clk);
    reqValid = 1'b1;
    reqOp = 2'(op);
    reqSet = 4'(s);
    reqWay = 2'(w);
    #1;
    checkBoth("R5/R8 pre-edge victim", s);
    @(posedge clk);
    #1;
    modelApply(op, s, w);
  endtask

  task automatic peek(string tag, int s);
    @(negedge clk);
    reqValid = 1'b0;
    reqSet = 4'(s);
    #1;
    checkBoth(tag, s);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 2; k++)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) mAge[k][s][w] = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: every set reports way 0 after reset
    for (int s = 0; s < SETS; s++) begin
      peek("R1 reset", s);
      check("R1 reset literal", int'(victimWay), 0);
    end

    // R3: fill ways 0..3 of set 5 -> ages 0,1,2,3 (two states: 0,0,0,1)
    for (int w = 0; w < WAYS; w++) doOp(2, 5, w);
    peek("R3 fill sequence", 5);
    check("R3 fill literal", int'(victimWay), 0);
    check("R3 R9 fill literal", int'(victimWayTwo), 0);

    // R2: hit way 0 -> ages 3,0,1,2 (two states: 1,0,0,0), victim way 1
    doOp(1, 5, 0);
    peek("R2 hit", 5);
    check("R2 hit literal", int'(victimWay), 1);
    check("R2 R9 hit literal", int'(victimWayTwo), 1);

    // R6: query op and idle leave the set unchanged
    doOp(0, 5, 1);
    peek("R6 after query", 5);
    check("R6 query literal", int'(victimWay), 1);

    // R4: invalidate way 0 -> ages 0,0,1,2, victim way 0
    doOp(3, 5, 0);
    peek("R4 invalidate", 5);
    check("R4 invalidate literal", int'(victimWay), 0);

    // R7: neighbour sets untouched
    peek("R7 neighbour", 4);
    check("R7 neighbour literal", int'(victimWay), 0);
    peek("R7 neighbour", 6);

    // Fill a whole set then hit each way in order: drives ages toward the maximum
    for (int w = 0; w < WAYS; w++) doOp(2, 9, w);
    for (int w = WAYS - 1; w >= 0; w--) doOp(1, 9, w);
    peek("R2/R5 hit sweep", 9);

    // Random mix on a small set pool, with periodic sweeps of every set
    for (int n = 0; n < 3000; n++) begin
      int s = (($urandom % 4) == 0) ? int'($urandom % SETS) : int'($urandom % 3);
      int op = int'($urandom % 4);
      int w = int'($urandom % WAYS);
      if (($urandom % 8) == 0) peek("R6 idle random", s);
      else doOp(op, s, w);
      if ((n % 250) == 249)
        for (int t = 0; t < SETS; t++) peek("R7 sweep", t);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule